// File: doc/BRIEF.md
# UART Transmit Queue with Level-Triggered Interrupt

This block sits between a host and the bit serializer of one UART channel. The host pushes bytes into a 64-entry queue. The block hands them one at a time to the serializer through a load pulse, and a done pulse returns from the serializer when a byte has left the line. Two status flags are kept apart. One says the queue is empty. The other says the queue and the shift stage are both idle.

A transmit interrupt tells the host to refill. It fires when the fill level crosses from at or above a selectable threshold to below it, and again when the queue drains to zero. Once raised, it stays pending until the host writes a byte or reads the interrupt status. An enable input masks its output without losing the pending state.

Flow control is represented only by a stall input, which holds back the next load. With the queue switched off, the block acts as a single holding register and keeps the same flags.

Top module: `uart_txq`

## Requirements
- R1: Bytes reach `ser_data` in the order they were accepted, up to DEPTH (64) of them queued. There is one `ser_load` pulse per byte, and no new load is issued while a loaded byte has not yet been answered by `ser_done`.
- R2: `thr_empty` is 1 exactly when no accepted byte is waiting in the queue.
- R3: A pending transmit event is latched when the fill level falls from at or above the threshold to below it. One is also latched when the level goes from nonzero to zero.
- R4: `irq` equals the pending event ANDed with `irq_en`. The pending state is kept while `irq_en` is 0.
- R5: `tx_empty` is 1 only when the queue is empty and no loaded byte is still waiting for its `ser_done`.
- R6: `trig_sel` picks the threshold: 2'b00 gives DEPTH/8 (8), 2'b01 gives DEPTH/4 (16), 2'b10 gives DEPTH/2 (32) and 2'b11 gives DEPTH-DEPTH/8 (56).
- R7: An accepted write or an `isr_rd` pulse clears the pending event. Below the threshold, no new crossing event can occur until the level has been back at or above the threshold. Only the empty event remains.
- R8: A write while the queue holds its full capacity is dropped, and the stored bytes are unchanged.
- R9: With `fifo_en` at 0 the capacity is one byte. Any change of `fifo_en` discards the queued bytes.
- R10: While `stall` is 1 no new `ser_load` is issued. A byte already loaded still completes, and its `ser_done` is accepted.
- R11: After reset, `thr_empty` and `tx_empty` are 1, and `irq` and `ser_load` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1: queue of DEPTH bytes, 0: single holding register |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| trig_sel | input | 2 | Threshold select |
| irq_en | input | 1 | Transmit interrupt enable |
| isr_rd | input | 1 | Host read of interrupt status, clears pending |
| stall | input | 1 | Flow-control hold of the next load |
| ser_done | input | 1 | Serializer finished the loaded byte |
| ser_load | output | 1 | One-cycle load pulse to the serializer |
| ser_data | output | 8 | Byte presented with `ser_load` |
| thr_empty | output | 1 | Queue holds no bytes |
| tx_empty | output | 1 | Queue and shift stage both idle |
| irq | output | 1 | Masked transmit interrupt |

## Verification
The bench fills the queue to capacity and then offers one more byte. A design that wraps its write pointer would overwrite the oldest byte, or it would emit 65 loads. It drains from threshold plus two for every threshold encoding and records the load at which `irq` rises. A wrong threshold table, or a test of "at or below" instead of "below", shifts that load count by one or more. After the host clears the interrupt, the bench confirms that the next rise comes only at empty; a design that re-fires on every level below the threshold would rise one load later. It also holds `stall` while a byte is being shifted, checks the single-byte mode and the flush that follows a mode change, and checks that `irq_en` hides the pending event without discarding it.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'b00:   trig_level = depth / 8;
      2'b01:   trig_level = depth / 4;
      2'b10:   trig_level = depth / 2;
      default: trig_level = depth - depth / 8;
    endcase
  endfunction

endpackage

// File: rtl/uart_txq_ram.sv
module uart_txq_ram #(
  parameter int DW = 8,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/uart_txq_ctrl.sv
module uart_txq_ctrl #(
  parameter int DW = 8,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          stall,
  input  logic          ser_done,
  output logic          ser_load,
  output logic [DW-1:0] ser_data,
  output logic [CW-1:0] level,
  output logic          busy,
  output logic          wr_acc
);
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          mode_q;
  logic          flush, push, pop;
  logic [CW-1:0] cap;

  assign flush  = (fifo_en != mode_q);
  assign cap    = fifo_en ? CW'(DEPTH) : CW'(1);
  assign push   = wr_en && (level < cap) && !flush;
  assign pop    = (level != '0) && !busy && !stall && !flush;
  assign wr_acc = push;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      busy     <= 1'b0;
      ser_load <= 1'b0;
      mode_q   <= fifo_en;
    end else begin
      mode_q   <= fifo_en;
      ser_load <= pop;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        level  <= '0;
      end else begin
        if (push) wr_ptr <= wr_ptr + 1'b1;
        if (pop)  rd_ptr <= rd_ptr + 1'b1;
        level <= level + CW'(push) - CW'(pop);
      end
      if (pop)           busy <= 1'b1;
      else if (ser_done) busy <= 1'b0;
    end
  end

  uart_txq_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (push),
    .waddr (wr_ptr),
    .wdata (wr_data),
    .re    (pop),
    .raddr (rd_ptr),
    .rdata (ser_data)
  );

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));

  assert_full_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && level == CW'(DEPTH) && busy && !ser_done && fifo_en && !flush) |=> level == $past(level));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    stall |=> !ser_load);

  assert_one_inflight_R1: assert property (@(posedge clk) disable iff (rst)
    ser_load |=> !ser_load);

  assert_single_R9: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && !mode_q) |=> level <= CW'(1));
endmodule

// File: rtl/uart_txq_irq.sv
module uart_txq_irq #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] level,
  input  logic          wr_acc,
  input  logic          isr_rd,
  output logic          pending
);
  import uart_txq_pkg::*;

  logic [CW-1:0] thresh;
  logic below, above_q, nonempty_q, cross_evt, empty_evt;

  assign thresh    = CW'(trig_level(trig_sel, DEPTH));
  assign below     = fifo_en ? (level < thresh) : (level == '0);
  assign cross_evt = above_q && below;
  assign empty_evt = nonempty_q && (level == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      above_q    <= 1'b0;
      nonempty_q <= 1'b0;
      pending    <= 1'b0;
    end else begin
      above_q    <= !below;
      nonempty_q <= (level != '0);
      if (cross_evt || empty_evt)  pending <= 1'b1;
      else if (wr_acc || isr_rd)   pending <= 1'b0;
    end
  end

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    ((wr_acc || isr_rd) && $stable(level)) |=> !pending);
endmodule

// File: rtl/uart_txq.sv
module uart_txq #(
  parameter int DW = 8,
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    trig_sel,
  input  logic          irq_en,
  input  logic          isr_rd,
  input  logic          stall,
  input  logic          ser_done,
  output logic          ser_load,
  output logic [DW-1:0] ser_data,
  output logic          thr_empty,
  output logic          tx_empty,
  output logic          irq
);
  logic [CW-1:0] level;
  logic          busy, wr_acc, pending;

  uart_txq_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .fifo_en  (fifo_en),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .stall    (stall),
    .ser_done (ser_done),
    .ser_load (ser_load),
    .ser_data (ser_data),
    .level    (level),
    .busy     (busy),
    .wr_acc   (wr_acc)
  );

  uart_txq_irq #(.DEPTH(DEPTH)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .fifo_en  (fifo_en),
    .trig_sel (trig_sel),
    .level    (level),
    .wr_acc   (wr_acc),
    .isr_rd   (isr_rd),
    .pending  (pending)
  );

  assign thr_empty = (level == '0);
  assign tx_empty  = thr_empty && !busy;
  assign irq       = pending && irq_en;

  assert_empty_event_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(thr_empty) |=> pending);

  assert_shift_busy_R5: assert property (@(posedge clk) disable iff (rst)
    ser_load |-> !tx_empty);

  assert_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (pending && !wr_acc && !isr_rd) |=> pending);
endmodule

// File: tb/uart_txq_tb.sv
module uart_txq_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, fifo_en, wr_en, irq_en, isr_rd, stall, ser_done;
  logic [7:0] wr_data, ser_data;
  logic [1:0] trig_sel;
  logic ser_load, thr_empty, tx_empty, irq;

  uart_txq u_dut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .wr_en(wr_en), .wr_data(wr_data),
    .trig_sel(trig_sel), .irq_en(irq_en), .isr_rd(isr_rd), .stall(stall),
    .ser_done(ser_done), .ser_load(ser_load), .ser_data(ser_data),
    .thr_empty(thr_empty), .tx_empty(tx_empty), .irq(irq)
  );

  int total = 0, bad = 0, cyc = 0;
  int loads, rise_at, cnt, dly;
  logic clr, clr_rise, irq_prev;
  logic [7:0] got [0:127];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst || clr) begin
      loads = 0; rise_at = -1; cnt = 0; ser_done = 1'b0;
    end else begin
      ser_done = 1'b0;
      if (cnt > 0) begin
        cnt = cnt - 1;
        if (cnt == 0) ser_done = 1'b1;
      end
      if (ser_load) begin
        got[loads] = ser_data;
        loads = loads + 1;
        cnt = dly;
      end
    end
    if (clr_rise) rise_at = -1;
    if (irq && !irq_prev && rise_at < 0) rise_at = loads;
    irq_prev = irq;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_counts();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  task automatic pulse_isr();
    isr_rd = 1'b1; clr_rise = 1'b1; @(negedge clk); isr_rd = 1'b0; clr_rise = 1'b0;
  endtask

  initial begin
    rst = 1'b1; fifo_en = 1'b1; wr_en = 1'b0; wr_data = 8'h00; trig_sel = 2'b01;
    irq_en = 1'b1; isr_rd = 1'b0; stall = 1'b0; clr = 1'b0; clr_rise = 1'b0;
    irq_prev = 1'b0; dly = 3;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(thr_empty == 1'b1, "R11 thr_empty", int'(thr_empty), 1);
    chk(tx_empty == 1'b1, "R11 tx_empty", int'(tx_empty), 1);
    chk(irq == 1'b0, "R11 irq", int'(irq), 0);
    chk(ser_load == 1'b0, "R11 ser_load", int'(ser_load), 0);

    // Fill to capacity with stall, then one extra byte (R8)
    stall = 1'b1;
    for (int i = 0; i < 64; i++) wr(8'(i * 3 + 1));
    wr(8'hEE);
    chk(thr_empty == 1'b0, "R2 thr_empty full", int'(thr_empty), 0);
    chk(tx_empty == 1'b0, "R5 tx_empty full", int'(tx_empty), 0);
    chk(loads == 0, "R10 no load while stalled", loads, 0);
    clear_counts();
    stall = 1'b0;
    wait (rise_at >= 0);
    @(negedge clk);
    chk(rise_at == 49, "R3 R6 fall below 16", rise_at, 49);
    pulse_isr();
    chk(irq == 1'b0, "R7 isr read clears", int'(irq), 0);
    wait (loads == 64);
    @(negedge clk);
    chk(thr_empty == 1'b1, "R2 drained", int'(thr_empty), 1);
    chk(tx_empty == 1'b0, "R5 last byte shifting", int'(tx_empty), 0);
    wait (tx_empty);
    repeat (4) @(negedge clk);
    chk(loads == 64, "R8 full write dropped", loads, 64);
    for (int i = 0; i < 64; i++)
      chk(got[i] == 8'(i * 3 + 1), "R1 order", int'(got[i]), (i * 3 + 1) % 256);
    chk(rise_at == 64, "R3 empty event", rise_at, 64);

    // Threshold sweep (R6, R7)
    for (int s = 0; s < 4; s++) begin
      int t;
      t = (s == 0) ? 8 : (s == 1) ? 16 : (s == 2) ? 32 : 56;
      trig_sel = 2'(s);
      stall = 1'b1;
      clear_counts();
      for (int i = 0; i < t + 2; i++) wr(8'(i));
      @(negedge clk);
      chk(irq == 1'b0, "R7 write clears", int'(irq), 0);
      clr_rise = 1'b1; @(negedge clk); clr_rise = 1'b0;
      stall = 1'b0;
      wait (rise_at >= 0);
      @(negedge clk);
      chk(rise_at == 3, "R6 threshold crossing", rise_at, 3);
      pulse_isr();
      wait (tx_empty);
      repeat (4) @(negedge clk);
      chk(rise_at == t + 2, "R7 no refire below threshold", rise_at, t + 2);
    end

    // Mask keeps pending (R4)
    irq_en = 1'b0; trig_sel = 2'b00; stall = 1'b1;
    wr(8'h11); wr(8'h22);
    clear_counts();
    stall = 1'b0;
    wait (loads == 2);
    wait (tx_empty);
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R4 masked", int'(irq), 0);
    irq_en = 1'b1;
    #0;
    chk(irq == 1'b1, "R4 pending kept", int'(irq), 1);

    // Stall with byte in flight (R10)
    stall = 1'b1;
    wr(8'h33);
    chk(irq == 1'b0, "R7 write clears masked pending", int'(irq), 0);
    dly = 20;
    clear_counts();
    stall = 1'b0;
    wait (loads == 1);
    @(negedge clk);
    stall = 1'b1;
    wr(8'h44); wr(8'h55);
    repeat (40) @(negedge clk);
    chk(loads == 1, "R10 stall holds load", loads, 1);
    chk(tx_empty == 1'b0, "R5 queue not empty", int'(tx_empty), 0);
    stall = 1'b0;
    repeat (3) @(negedge clk);
    chk(loads == 2, "R10 in-flight byte completed", loads, 2);
    chk(got[1] == 8'h44, "R1 next byte", int'(got[1]), 8'h44);
    wait (tx_empty);
    dly = 3;
    repeat (4) @(negedge clk);

    // Single-byte mode (R9)
    fifo_en = 1'b0;
    repeat (2) @(negedge clk);
    stall = 1'b1;
    clear_counts();
    wr(8'h5A); wr(8'hA5);
    chk(thr_empty == 1'b0, "R2 holding full", int'(thr_empty), 0);
    stall = 1'b0;
    wait (tx_empty);
    repeat (4) @(negedge clk);
    chk(loads == 1, "R9 capacity one", loads, 1);
    chk(got[0] == 8'h5A, "R9 held byte", int'(got[0]), 8'h5A);
    chk(rise_at == 1, "R9 R3 empty event", rise_at, 1);

    // Mode change flushes (R9)
    stall = 1'b1;
    wr(8'h77);
    chk(thr_empty == 1'b0, "R9 byte held", int'(thr_empty), 0);
    fifo_en = 1'b1;
    @(negedge clk);
    chk(thr_empty == 1'b1, "R9 flush on mode change", int'(thr_empty), 1);
    stall = 1'b0;
    repeat (5) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule